// File: doc/BRIEF.md
# Binary32 Floating-Point Adder

This block adds two IEEE-754 single-precision operands and returns the sum rounded to nearest, with ties going to even. A caller subtracts by flipping the sign bit of the second operand before presenting it. The arithmetic is combinational. One output register holds the result and presents it one clock after the operands are accepted. Subnormal operands and subnormal results are handled fully.

The datapath is split into three parts:

- A classifier sorts each operand pair into one of seven verdicts:
  - `SP_NONE`: a finite, nonzero operand pair that takes the general path.
  - `SP_NAN_A`: the first operand is a NaN.
  - `SP_NAN_B`: the second operand is a NaN and the first is not.
  - `SP_INF_CLASH`: two infinities of opposite sign.
  - `SP_PASS_A`: the first operand is returned unchanged.
  - `SP_PASS_B`: the second operand is returned unchanged.
  - `SP_ZERO_AND`: both operands are zero.
- An alignment stage orders the operands by magnitude, normalises subnormals, and right-shifts the smaller significand with a sticky bit. Every significand carries three extra low bits.
- A rounding stage adds or subtracts, renormalises, denormalises underflowing results, detects overflow and rounds.

A `unique case` on the verdict picks either a special-case value or the general-path sum. The output register loads on `in_valid`. `out_valid` repeats `in_valid` one cycle later. There is no other state and no state machine.

Top module: `fpadd32`

## Requirements
- R1: `out_valid` equals the value `in_valid` had on the previous clock edge. A synchronous active-high `rst` clears both `out_valid` and `result` to zero.
- R2: `result` loads only on clock edges where `in_valid` is high. Otherwise it keeps its value, whatever the operands are.
- R3: NaN results use this layout: sign in bit 31, exponent in bits 30:23, mantissa in bits 22:0. A NaN has an all-ones exponent and a nonzero mantissa.
  - If `op_a` is a NaN, the result is bits 30:0 of `op_a` with bit 22 (the quiet bit) forced to 1 and bit 31 cleared.
  - Otherwise, if `op_b` is a NaN, the same rule applies to `op_b`.
- R4: An infinity added to the infinity of opposite sign gives 0x7FC00000. In any other case with an infinite operand, that operand is returned unchanged, and `op_a` is checked first.
- R5: Zero plus zero gives the bitwise AND of the two operands, so only −0 + −0 gives 0x80000000. Zero plus a nonzero operand returns the nonzero operand bit for bit.
- R6: Two finite operands of equal magnitude and opposite sign give +0 (0x00000000).
- R7: Any other finite sum is the exact sum rounded to nearest, ties to even. This includes sums that end up subnormal.
- R8: A sum whose magnitude overflows gives infinity with the sign of the larger-magnitude operand. The overflow may come before rounding or from the rounding carry. Infinity is exponent 0xFF with mantissa 0.
- R9: A nonzero finite result takes the sign of the operand with the larger magnitude.
- R10: Operands whose exponents differ by 28 or more still round correctly. The smaller operand then contributes only a sticky bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are presented this cycle |
| op_a | input | 32 | First addend, binary32 |
| op_b | input | 32 | Second addend, binary32 |
| out_valid | output | 1 | `result` holds a fresh sum |
| result | output | 32 | Rounded sum, binary32 |

## Verification
Renormalisation and rounding can both move the exponent in the same cycle. Two cases stand out:

- An addition that carries out of the significand can then have its rounding increment overflow to infinity.
- A cancelling subtraction can shift left and then fall into the subnormal shift.

The bench forces these collisions with directed pairs:

- the largest finite value plus exactly half of its unit in the last place;
- a near-cancelling pair;
- subnormal pairs whose sum crosses into the normal range.

The bench also streams thousands of operand pairs that are random or have nearby exponents. Every result is judged against a model that forms the exact sum as a wide integer and rounds it only once.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;

    // Verdict of the special-operand classifier; SP_NONE selects the datapath.
    typedef enum logic [2:0] {
        SP_NONE,
        SP_NAN_A,
        SP_NAN_B,
        SP_INF_CLASH,
        SP_PASS_A,
        SP_PASS_B,
        SP_ZERO_AND
    } sp_kind_e;

endpackage

// File: rtl/fpadd_lzc.sv
module fpadd_lzc #(
    parameter int WIDTH = 24,
    localparam int CW = $clog2(WIDTH + 1)
) (
    input  logic [WIDTH-1:0] vec,
    output logic [CW-1:0]    count
);
    always_comb begin
        count = CW'(WIDTH);
        for (int i = 0; i < WIDTH; i++) begin
            if (vec[i]) count = CW'(WIDTH - 1 - i);
        end
    end
endmodule

// File: rtl/fpadd_classify.sv
module fpadd_classify
    import fpadd_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int W = 1 + EXP_W + MAN_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output sp_kind_e     kind
);
    localparam logic [W-2:0] INF_M  = {{EXP_W{1'b1}}, {MAN_W{1'b0}}};
    localparam logic [W-2:0] ONE_M  = (W-1)'(1);
    localparam logic [W-1:0] SIGN_M = {1'b1, {(W-1){1'b0}}};

    logic [W-2:0] a_mag, b_mag;
    logic         a_odd, b_odd;

    assign a_mag = a[W-2:0];
    assign b_mag = b[W-2:0];
    // Wrapping compare flags zero, infinity and NaN in one step.
    assign a_odd = (a_mag - ONE_M) >= (INF_M - ONE_M);
    assign b_odd = (b_mag - ONE_M) >= (INF_M - ONE_M);

    always_comb begin
        kind = SP_NONE;
        if (a_odd || b_odd) begin
            if (a_mag > INF_M)             kind = SP_NAN_A;
            else if (b_mag > INF_M)        kind = SP_NAN_B;
            else if (a_mag == INF_M)       kind = ((a ^ b) == SIGN_M) ? SP_INF_CLASH : SP_PASS_A;
            else if (b_mag == INF_M)       kind = SP_PASS_B;
            else if (a_mag == '0)          kind = (b_mag == '0) ? SP_ZERO_AND : SP_PASS_B;
            else                           kind = SP_PASS_A;
        end
    end
endmodule

// File: rtl/fpadd_align.sv
module fpadd_align #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int W     = 1 + EXP_W + MAN_W,
    localparam int SIG_W = MAN_W + 1,
    localparam int WK    = MAN_W + 5,
    localparam int EI_W  = EXP_W + 2
) (
    input  logic                   [W-1:0]  a,
    input  logic                   [W-1:0]  b,
    output logic                            big_sign,
    output logic                            eff_sub,
    output logic signed            [EI_W-1:0] big_exp,
    output logic                   [WK-1:0] big_sig,
    output logic                   [WK-1:0] small_sig
);
    localparam int LZ_W = $clog2(SIG_W + 1);
    localparam int SH_W = $clog2(WK + 1);
    localparam logic signed [EI_W-1:0] ONE_S = EI_W'(1);
    localparam logic signed [EI_W-1:0] WK_S  = EI_W'(WK);

    logic         swap;
    logic [W-1:0] opnd [2];

    assign swap    = b[W-2:0] > a[W-2:0];
    assign opnd[0] = swap ? b : a;
    assign opnd[1] = swap ? a : b;

    // Unpack both operands the same way: hidden bit, subnormal normalisation, 3 spare bits.
    for (genvar gi = 0; gi < 2; gi++) begin : g_unpack
        logic [EXP_W-1:0]       fexp;
        logic [SIG_W-1:0]       raw;
        logic [LZ_W-1:0]        lz;
        logic [WK-1:0]          ext;
        logic signed [EI_W-1:0] nexp;

        assign fexp = opnd[gi][W-2:MAN_W];
        assign raw  = {1'b0, opnd[gi][MAN_W-1:0]};

        fpadd_lzc #(.WIDTH(SIG_W)) u_lzc (.vec(raw), .count(lz));

        always_comb begin
            if (fexp == '0) begin
                ext  = {1'b0, raw << lz, 3'b000};
                nexp = ONE_S - $signed({{(EI_W-LZ_W){1'b0}}, lz});
            end else begin
                ext  = {1'b0, 1'b1, raw[MAN_W-1:0], 3'b000};
                nexp = $signed({2'b00, fexp});
            end
        end
    end

    logic signed [EI_W-1:0] diff;
    logic [SH_W-1:0]        sh;
    logic [WK-1:0]          lo_ext;

    assign diff   = g_unpack[0].nexp - g_unpack[1].nexp;
    assign lo_ext = g_unpack[1].ext;

    always_comb begin
        sh        = '0;
        small_sig = lo_ext;
        if (diff >= WK_S) begin
            small_sig = WK'(1);
        end else begin
            sh        = diff[SH_W-1:0];
            small_sig = (lo_ext >> sh)
                      | {{(WK-1){1'b0}}, |(lo_ext & ~({WK{1'b1}} << sh))};
        end
    end

    assign big_sig  = g_unpack[0].ext;
    assign big_exp  = g_unpack[0].nexp;
    assign big_sign = opnd[0][W-1];
    assign eff_sub  = a[W-1] ^ b[W-1];

    // r10: after alignment the smaller significand never exceeds the larger one
    always_comb begin
        p_align_order_r10: assert (small_sig <= big_sig);
    end
endmodule

// File: rtl/fpadd_round.sv
module fpadd_round #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int W    = 1 + EXP_W + MAN_W,
    localparam int WK   = MAN_W + 5,
    localparam int EI_W = EXP_W + 2
) (
    input  logic                   big_sign,
    input  logic                   eff_sub,
    input  logic signed [EI_W-1:0] big_exp,
    input  logic        [WK-1:0]   big_sig,
    input  logic        [WK-1:0]   small_sig,
    output logic        [W-1:0]    res
);
    localparam int LZ_W = $clog2(WK);
    localparam int SH_W = $clog2(WK + 1);
    localparam logic signed [EI_W-1:0] ONE_S  = EI_W'(1);
    localparam logic signed [EI_W-1:0] WK_S   = EI_W'(WK);
    localparam logic signed [EI_W-1:0] EMAX_S = EI_W'((1 << EXP_W) - 1);

    logic [WK-1:0]   raw_sum;
    logic [LZ_W-1:0] lz;

    assign raw_sum = eff_sub ? (big_sig - small_sig) : (big_sig + small_sig);

    fpadd_lzc #(.WIDTH(WK-1)) u_lzc (.vec(raw_sum[WK-2:0]), .count(lz));

    logic [WK-1:0]          s;
    logic signed [EI_W-1:0] e;
    logic signed [EI_W-1:0] dsh;
    logic [SH_W-1:0]        sh;
    logic [W-2:0]           mag;

    always_comb begin
        s   = raw_sum;
        e   = big_exp;
        dsh = '0;
        sh  = '0;
        mag = '0;
        res = '0;
        if (eff_sub) begin
            if (!s[WK-2]) begin
                s = s << lz;
                e = e - $signed({{(EI_W-LZ_W){1'b0}}, lz});
            end
        end else if (s[WK-1]) begin
            s = {1'b0, s[WK-1:1]} | {{(WK-1){1'b0}}, s[0]};
            e = e + ONE_S;
        end

        if (s == '0) begin
            res = '0;
        end else if (e >= EMAX_S) begin
            res = {big_sign, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
        end else begin
            if (e <= 0) begin
                dsh = ONE_S - e;
                if (dsh >= WK_S) begin
                    s = WK'(1);
                end else begin
                    sh = dsh[SH_W-1:0];
                    s  = (s >> sh) | {{(WK-1){1'b0}}, |(s & ~({WK{1'b1}} << sh))};
                end
                e = '0;
            end
            mag = {e[EXP_W-1:0], s[MAN_W+2:3]};
            if (s[2:0] > 3'd4)       mag = mag + (W-1)'(1);
            else if (s[2:0] == 3'd4) mag = mag + {{(W-2){1'b0}}, mag[0]};
            res = {big_sign, mag};
        end
    end

    // r8: the general path yields infinity or finite values, never a NaN pattern
    always_comb begin
        if (res[W-2:MAN_W] == {EXP_W{1'b1}}) begin
            p_core_no_nan_r8: assert (res[MAN_W-1:0] == '0);
        end
    end
endmodule

// File: rtl/fpadd32.sv
module fpadd32
    import fpadd_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int W    = 1 + EXP_W + MAN_W,
    localparam int WK   = MAN_W + 5,
    localparam int EI_W = EXP_W + 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic         out_valid,
    output logic [W-1:0] result
);
    localparam logic [W-2:0] INF_M   = {{EXP_W{1'b1}}, {MAN_W{1'b0}}};
    localparam logic [W-2:0] QUIET_M = (W-1)'(1) << (MAN_W - 1);
    localparam logic [W-1:0] SIGN_M  = {1'b1, {(W-1){1'b0}}};

    sp_kind_e               kind;
    logic                   big_sign, eff_sub;
    logic signed [EI_W-1:0] big_exp;
    logic [WK-1:0]          big_sig, small_sig;
    logic [W-1:0]           core_res;
    logic [W-1:0]           next_res;

    fpadd_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_classify (
        .a(op_a), .b(op_b), .kind(kind)
    );

    fpadd_align #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_align (
        .a(op_a), .b(op_b),
        .big_sign(big_sign), .eff_sub(eff_sub), .big_exp(big_exp),
        .big_sig(big_sig), .small_sig(small_sig)
    );

    fpadd_round #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_round (
        .big_sign(big_sign), .eff_sub(eff_sub), .big_exp(big_exp),
        .big_sig(big_sig), .small_sig(small_sig), .res(core_res)
    );

    always_comb begin
        unique case (kind)
            SP_NAN_A:     next_res = {1'b0, op_a[W-2:0] | QUIET_M};
            SP_NAN_B:     next_res = {1'b0, op_b[W-2:0] | QUIET_M};
            SP_INF_CLASH: next_res = {1'b0, INF_M | QUIET_M};
            SP_PASS_A:    next_res = op_a;
            SP_PASS_B:    next_res = op_b;
            SP_ZERO_AND:  next_res = op_a & op_b;
            default:      next_res = core_res;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= next_res;
        end
    end

    p_valid_follow_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_valid_drop_r1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));

    p_nan_a_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_a[W-2:0] > INF_M)
        |=> result == {1'b0, $past(op_a[W-2:0]) | QUIET_M});

    p_inf_clash_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_a[W-2:0] == INF_M && op_b == (op_a ^ SIGN_M))
        |=> result == {1'b0, INF_M | QUIET_M});

    p_cancel_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_a[W-2:MAN_W] != {EXP_W{1'b1}} && op_b == (op_a ^ SIGN_M))
        |=> result == '0);
endmodule

// File: tb/fpadd32_test.sv
module fpadd32_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        out_valid;
    logic [31:0] result;

    int    checks = 0;
    int    errors = 0;
    bit    check_en = 1'b0;
    bit    done = 1'b0;
    string cur_tag = "R7";

    logic        exp_v = 1'b0;
    logic [31:0] exp_r = '0;
    logic [31:0] exp_a = '0;
    logic [31:0] exp_b = '0;
    string       tag_q = "R1";

    fpadd32 uut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b),
        .out_valid(out_valid), .result(result)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [299:0] widen(logic [31:0] x);
        logic [23:0] sig;
        int          sh;
        sig = (x[30:23] == 8'h00) ? {1'b0, x[22:0]} : {1'b1, x[22:0]};
        sh  = (x[30:23] == 8'h00) ? 0 : int'(x[30:23]) - 1;
        return 300'(sig) << sh;
    endfunction

    // Exact-sum model: value = integer * 2^-149, rounded once to nearest-even.
    function automatic logic [31:0] ref_add(logic [31:0] a, logic [31:0] b);
        logic [30:0]  ma, mb;
        logic [299:0] va, vb, mag, kept, rem, half;
        logic         sg;
        int           p, s;
        ma = a[30:0];
        mb = b[30:0];
        if (ma > 31'h7F800000) return {1'b0, ma | 31'h00400000};
        if (mb > 31'h7F800000) return {1'b0, mb | 31'h00400000};
        if (ma == 31'h7F800000)
            return (mb == 31'h7F800000 && a[31] != b[31]) ? 32'h7FC00000 : a;
        if (mb == 31'h7F800000) return b;
        if (ma == 0) return (mb == 0) ? (a & b) : b;
        if (mb == 0) return a;
        va = widen(a);
        vb = widen(b);
        if (a[31] == b[31]) begin
            mag = va + vb; sg = a[31];
        end else if (va >= vb) begin
            mag = va - vb; sg = a[31];
        end else begin
            mag = vb - va; sg = b[31];
        end
        if (mag == 0) return 32'h0;
        p = 0;
        for (int i = 0; i < 300; i++) if (mag[i]) p = i;
        if (p <= 23) return {sg, mag[30:0]};
        s    = p - 23;
        kept = mag >> s;
        rem  = mag & ((300'd1 << s) - 300'd1);
        half = 300'd1 << (s - 1);
        if (rem > half || (rem == half && kept[0])) kept = kept + 300'd1;
        if (kept[24]) begin
            kept = kept >> 1;
            s    = s + 1;
        end
        if (s + 1 >= 255) return {sg, 8'hFF, 23'h0};
        return {sg, 8'(s + 1), kept[22:0]};
    endfunction

    // Behavioural expectation, advanced on every rising edge.
    always @(posedge clk) begin
        if (rst) begin
            exp_v <= 1'b0;
            exp_r <= '0;
            tag_q <= "R1";
        end else begin
            exp_v <= in_valid;
            if (in_valid) begin
                exp_r <= ref_add(op_a, op_b);
                exp_a <= op_a;
                exp_b <= op_b;
                tag_q <= cur_tag;
            end else begin
                tag_q <= "R2";
            end
        end
    end

    // Compare away from the active edge, every cycle.
    always @(negedge clk) begin
        if (check_en && !done) begin
            checks++;
            if (out_valid !== exp_v) begin
                errors++;
                $display("FAIL R1: out_valid=%b expected=%b", out_valid, exp_v);
            end
            checks++;
            if (result !== exp_r) begin
                errors++;
                $display("FAIL %s: result=%h expected=%h (a=%h b=%h)",
                         tag_q, result, exp_r, exp_a, exp_b);
            end
        end
    end

    task automatic send(input logic [31:0] a, input logic [31:0] b, input string tag);
        @(negedge clk);
        op_a     = a;
        op_b     = b;
        in_valid = 1'b1;
        cur_tag  = tag;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            op_a     = $urandom;
            op_b     = $urandom;
        end
    endtask

    initial begin
        repeat (2) @(posedge clk);
        check_en = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R3 NaN propagation
        send(32'hFF800001, 32'h3F800000, "R3");
        send(32'h3F800000, 32'h7F812345, "R3");
        send(32'h7FA00000, 32'hFFC00003, "R3");
        // R4 infinities
        send(32'h7F800000, 32'hFF800000, "R4");
        send(32'hFF800000, 32'h3F800000, "R4");
        send(32'h3F800000, 32'h7F800000, "R4");
        send(32'h7F800000, 32'h7F800000, "R4");
        // R2 hold while idle with changing operands
        idle(3);
        // R5 zeros
        send(32'h80000000, 32'h80000000, "R5");
        send(32'h80000000, 32'h00000000, "R5");
        send(32'h00000000, 32'hC0000000, "R5");
        send(32'h00000001, 32'h80000000, "R5");
        // R6 exact cancellation
        send(32'h3F800000, 32'hBF800000, "R6");
        send(32'h80000005, 32'h00000005, "R6");
        // R7 rounding, including subnormal results
        send(32'h3F800000, 32'h3F800000, "R7");
        send(32'h3F800000, 32'h33800000, "R7");
        send(32'h3F800000, 32'h33C00000, "R7");
        send(32'h3F800001, 32'h33800000, "R7");
        send(32'h00000001, 32'h00000001, "R7");
        send(32'h007FFFFF, 32'h00000001, "R7");
        send(32'h00800000, 32'h80000001, "R7");
        send(32'h4B000000, 32'h3F000001, "R7");
        // R8 overflow, before and through rounding
        send(32'h7F7FFFFF, 32'h7F7FFFFF, "R8");
        send(32'hFF7FFFFF, 32'hFF7FFFFF, "R8");
        send(32'h7F7FFFFF, 32'h73000000, "R8");
        send(32'h7F7FFFFF, 32'h72FFFFFF, "R8");
        // R9 sign of the larger magnitude
        send(32'h3F800000, 32'hC0000000, "R9");
        send(32'hC0400000, 32'h40000000, "R9");
        // R10 far alignment
        send(32'h3F800000, 32'h00000001, "R10");
        send(32'h3F800000, 32'hB3800001, "R10");
        send(32'h7F000000, 32'h00000003, "R10");
        send(32'h3F800000, 32'hA0000000, "R10");
        idle(2);

        // R7 streamed patterns: random, close exponents, subnormal, near-cancel
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] a, b;
            a = $urandom;
            case ($urandom_range(0, 3))
                0: b = $urandom;
                1: b = {1'($urandom), a[30:23] + 8'($urandom_range(0, 6)) - 8'd3,
                        23'($urandom)};
                2: begin
                    a = {1'($urandom), 8'h00, 23'($urandom)};
                    b = {1'($urandom), 8'($urandom_range(0, 2)), 23'($urandom)};
                end
                default: b = a ^ 32'h80000000 ^ 32'($urandom_range(0, 7));
            endcase
            send(a, b, "R7");
            if (n % 97 == 0) idle(1);
        end
        idle(2);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule